// File: doc/BRIEF.md
# DMA Request Priority Mask Gate

This block stands between the per-channel DMA transfer request strobes and the channel arbiter. It compares the current CPU priority level against each channel's own priority level and, while masking is switched on, holds back any request whose channel ranks strictly below the CPU. A held request is not lost. It waits in a per-channel suspended flag and moves on to the arbiter by itself as soon as the CPU level drops or the channel level rises far enough. Clearing a channel's enable throws away whatever that channel holds.

Each channel drives one registered request-out line to the arbiter. The line stays high until the arbiter acknowledges that channel. A suspended-status vector shows which channels are currently held back by priority. When masking is off, the CPU counts as the lowest priority, so no channel is ever held. The block does not arbitrate among channels: every channel that is not held is passed on, whatever its rank against the others.

Top module: `dma_prio_gate`

## Requirements
- R1: After reset, every bit of `req_out` and `held` is 0.
- R2: A `req_stb` pulse on an enabled channel that is not blocked raises that channel's `req_out` bit at the next clock edge, and its `held` bit stays 0.
- R3: A raised `req_out` bit stays high until a cycle in which the matching `ack` bit is 1 is sampled, and it falls at that edge.
- R4: A channel is blocked when `mask_en` is 1 and `cpu_prio` is strictly greater than its level. A request on a blocked, enabled channel sets its `held` bit at the next edge and does not raise `req_out`.
- R5: A channel whose level equals or exceeds `cpu_prio` is never blocked, and its request is passed on as in R2.
- R6: When `cpu_prio` is lowered so that a held channel is no longer blocked, that channel's `req_out` rises and its `held` falls at the next edge.
- R7: When a held channel's own level is raised to `cpu_prio` or above, the request is released in the same way as in R6.
- R8: While a channel's `ch_en` bit is 0, both its `held` and its `req_out` bits are cleared at the next edge, so a cancelled request never reaches the arbiter afterwards.
- R9: With `mask_en` at 0, no channel is blocked, even when `cpu_prio` is 7 and the channel level is 0.
- R10: A `req_stb` pulse on a channel whose `ch_en` bit is 0 is ignored. It sets neither `held` nor `req_out`, and enabling the channel later does not bring it back.
- R11: Channels are independent. Channel c uses the level in `ch_prio[c*3 +: 3]`, and blocking one channel does not delay another.
- R12: For no channel are `held` and `req_out` both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_en | input | 1 | Global enable for CPU-priority masking |
| cpu_prio | input | 3 | Current CPU priority level |
| ch_en | input | 4 | Per-channel enable; 0 cancels that channel's request |
| ch_prio | input | 12 | Channel levels, channel c in bits c*3 +: 3 |
| req_stb | input | 4 | One-cycle transfer request strobe per channel |
| ack | input | 4 | Arbiter acknowledge per channel |
| req_out | output | 4 | Registered accepted request per channel |
| held | output | 4 | Per-channel suspended-request flag |

## Verification
The main function is tried with four kinds of level pattern. In the first, the CPU level is above the channel's, which shows whether the request is held. In the second, the two levels are equal, which tells a strict comparison from an inclusive one. In the third, the channel's level is above the CPU's. In the fourth, every channel is at level 0 under the highest CPU level with masking off, which shows whether the global switch is obeyed. Release is driven once by lowering the CPU level and once by raising the channel level, which tells whether the gate re-evaluates both operands. A mixed pattern with two channels held and two passed in the same cycle then separates per-channel gating from any shared decision. Cancel cases disable a channel while it is held and while it is accepted, and also before its strobe arrives.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

  // Channel is held back when masking is on and the CPU outranks it strictly.
  function automatic logic prio_blocks(input logic en,
                                       input logic [7:0] cpu_lvl,
                                       input logic [7:0] ch_lvl);
    return en && (cpu_lvl > ch_lvl);
  endfunction

endpackage

// File: rtl/dma_gate_cmp.sv
module dma_gate_cmp #(
  parameter int PRIO_W = 3
) (
  input  logic              mask_en,
  input  logic [PRIO_W-1:0] cpu_prio,
  input  logic [PRIO_W-1:0] ch_prio,
  output logic              blk
);
  import dma_gate_pkg::*;

  always_comb begin
    blk = prio_blocks(mask_en, 8'(cpu_prio), 8'(ch_prio));
  end

  // R9: the global switch off means nothing is ever blocked
  always_comb begin
    if (!mask_en) assert_unmasked_pass_R9: assert (blk == 1'b0);
  end
endmodule

// File: rtl/dma_gate_slot.sv
module dma_gate_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic ack,
  input  logic blk,
  output logic acc_q,
  output logic pend_q
);
  logic busy;
  logic want;
  logic acc_d;
  logic pend_d;

  always_comb begin
    busy   = acc_q & ~ack;
    want   = stb | pend_q;
    acc_d  = en & (busy | (want & ~blk));
    pend_d = en & ~busy & want & blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      pend_q <= pend_d;
    end
  end

  assert_accept_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en && !blk) |=> acc_q);

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !ack && en) |=> acc_q);

  assert_blocked_no_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!acc_q || ack) && blk) |=> !acc_q);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !blk && en) |=> (acc_q && !pend_q));

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!acc_q && !pend_q));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_q && pend_q));
endmodule

// File: rtl/dma_prio_gate.sv
module dma_prio_gate #(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 3,
  localparam int PW_ALL = NUM_CH * PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_en,
  input  logic [PRIO_W-1:0] cpu_prio,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [PW_ALL-1:0] ch_prio,
  input  logic [NUM_CH-1:0] req_stb,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] req_out,
  output logic [NUM_CH-1:0] held
);
  logic [NUM_CH-1:0] blk_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_gate_cmp #(.PRIO_W(PRIO_W)) cmp_i (
      .mask_en (mask_en),
      .cpu_prio(cpu_prio),
      .ch_prio (ch_prio[c*PRIO_W +: PRIO_W]),
      .blk     (blk_vec[c])
    );

    dma_gate_slot slot_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[c]),
      .stb   (req_stb[c]),
      .ack   (ack[c]),
      .blk   (blk_vec[c]),
      .acc_q (req_out[c]),
      .pend_q(held[c])
    );
  end

  // R1: outputs are clear in the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (req_out == '0 && held == '0));
endmodule

// File: tb/dma_prio_gate_tb.sv
module dma_prio_gate_tb_top;
  localparam int NC = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mask_en = 1'b1;
  logic [PW-1:0] cpu_prio = '0;
  logic [NC-1:0] ch_en = '1;
  logic [NC*PW-1:0] ch_prio = '0;
  logic [NC-1:0] req_stb = '0;
  logic [NC-1:0] ack = '0;
  logic [NC-1:0] req_out;
  logic [NC-1:0] held;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_prio_gate #(.NUM_CH(NC), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mask_en(mask_en), .cpu_prio(cpu_prio),
    .ch_en(ch_en), .ch_prio(ch_prio), .req_stb(req_stb), .ack(ack),
    .req_out(req_out), .held(held)
  );

  task automatic expect4(input string tag, input logic [NC-1:0] acc_exp,
                         input logic [NC-1:0] held_exp);
    n_chk++;
    if (req_out !== acc_exp || held !== held_exp) begin
      n_bad++;
      $display("FAIL %s: req_out=%b held=%b expected req_out=%b held=%b",
               tag, req_out, held, acc_exp, held_exp);
    end
  endtask

  task automatic set_lvl(input int ch, input int lvl);
    ch_prio[ch*PW +: PW] = PW'(lvl);
  endtask

  task automatic strobe(input logic [NC-1:0] m);
    @(negedge clk); req_stb = m;
    @(negedge clk); req_stb = '0;
  endtask

  task automatic pulse_ack(input logic [NC-1:0] m);
    @(negedge clk); ack = m;
    @(negedge clk); ack = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic defaults();
    @(negedge clk);
    mask_en = 1'b1; cpu_prio = '0; ch_en = '1;
    for (int c = 0; c < NC; c++) set_lvl(c, 3);
  endtask

  task automatic t_reset();
    idle(2);
    expect4("R1 during reset", 4'b0000, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    expect4("R1 after reset", 4'b0000, 4'b0000);
  endtask

  task automatic t_basic();
    defaults();
    strobe(4'b0001);
    expect4("R2 accepted next cycle", 4'b0001, 4'b0000);
    idle(3);
    expect4("R3 held until ack", 4'b0001, 4'b0000);
    pulse_ack(4'b0001);
    expect4("R3 cleared by ack", 4'b0000, 4'b0000);
  endtask

  task automatic t_block_cpu_drop();
    defaults();
    cpu_prio = 3'd5; set_lvl(1, 3);
    strobe(4'b0010);
    expect4("R4 masked request held", 4'b0000, 4'b0010);
    idle(3);
    expect4("R4 still held", 4'b0000, 4'b0010);
    cpu_prio = 3'd3;
    @(negedge clk);
    expect4("R6 released on cpu drop", 4'b0010, 4'b0000);
    pulse_ack(4'b0010);
  endtask

  task automatic t_equal_and_above();
    defaults();
    cpu_prio = 3'd4; set_lvl(2, 4); set_lvl(3, 6);
    strobe(4'b1100);
    expect4("R5 equal and higher pass", 4'b1100, 4'b0000);
    pulse_ack(4'b1100);
    expect4("R5 acked", 4'b0000, 4'b0000);
  endtask

  task automatic t_channel_raise();
    defaults();
    cpu_prio = 3'd6; set_lvl(0, 2);
    strobe(4'b0001);
    expect4("R7 held before raise", 4'b0000, 4'b0001);
    set_lvl(0, 7);
    @(negedge clk);
    expect4("R7 released on channel raise", 4'b0001, 4'b0000);
    pulse_ack(4'b0001);
  endtask

  task automatic t_cancel();
    defaults();
    cpu_prio = 3'd7; set_lvl(3, 1);
    strobe(4'b1000);
    expect4("R8 held before cancel", 4'b0000, 4'b1000);
    ch_en = 4'b0111;
    @(negedge clk);
    expect4("R8 held cleared by disable", 4'b0000, 4'b0000);
    cpu_prio = 3'd0; ch_en = 4'b1111;
    idle(2);
    expect4("R8 cancelled request stays gone", 4'b0000, 4'b0000);
    strobe(4'b0100);
    expect4("R8 accepted before cancel", 4'b0100, 4'b0000);
    ch_en = 4'b1011;
    @(negedge clk);
    expect4("R8 accepted cleared by disable", 4'b0000, 4'b0000);
  endtask

  task automatic t_nomask();
    defaults();
    mask_en = 1'b0; cpu_prio = 3'd7;
    for (int c = 0; c < NC; c++) set_lvl(c, 0);
    strobe(4'b1111);
    expect4("R9 masking off passes all", 4'b1111, 4'b0000);
    pulse_ack(4'b1111);
  endtask

  task automatic t_disabled();
    defaults();
    ch_en = 4'b1101;
    strobe(4'b0010);
    expect4("R10 disabled strobe ignored", 4'b0000, 4'b0000);
    ch_en = 4'b1111;
    idle(2);
    expect4("R10 no late acceptance", 4'b0000, 4'b0000);
  endtask

  task automatic t_mixed();
    defaults();
    cpu_prio = 3'd4;
    set_lvl(0, 1); set_lvl(1, 4); set_lvl(2, 5); set_lvl(3, 3);
    strobe(4'b1111);
    expect4("R11 mixed per-channel gating", 4'b0110, 4'b1001);
    n_chk++;
    if ((req_out & held) != '0) begin
      n_bad++;
      $display("FAIL R12: overlap=%b expected 0000", req_out & held);
    end
    mask_en = 1'b0;
    @(negedge clk);
    expect4("R11 held released by mask off", 4'b1111, 4'b0000);
    pulse_ack(4'b1111);
    expect4("R11 all acked", 4'b0000, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_block_cpu_drop();
    t_equal_and_above();
    t_channel_raise();
    t_cancel();
    t_nomask();
    t_disabled();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule